// File: doc/BRIEF.md
# Modulo 2^W−1 Residue Adder with Single Zero

This block adds two residues modulo 2^W−1 in one pass of combinational logic. Each operand is a W-bit value in the range 0 to 2^W−2, and the result is kept in the same range. The value 2^W−1, which is the all-ones word and a second form of zero, never appears on the output.

The datapath has three stages. A bitwise stage forms propagate (XOR) and generate (AND) terms. A parallel prefix network turns those terms into the carry into every bit. The topology of that network is chosen at elaboration: a log-depth Kogge-Stone tree or a sparser Brent-Kung up-sweep and down-sweep. The raw sum then goes to a correction stage built only from XOR and AND gates. This stage adds one when the prefix carry-out is set or when every bit propagates. Either case means the true sum is at least 2^W−1.

The block is meant for residue arithmetic channels and for reverse converters that need the 2^W−1 channel with a single representation of zero.

Top module: `modm1_adder`

## Requirements
- R1: When opa_i + opb_i < 2^W−1, res_o equals opa_i + opb_i.
- R2: When opa_i + opb_i ≥ 2^W, res_o equals opa_i + opb_i − (2^W−1). The prefix carry-out drives the one-step increment, and the carry out of that increment is dropped.
- R3: When opa_i + opb_i equals exactly 2^W−1, the operand bits never generate together and every bit propagates, and res_o is 0.
- R4: For operands in range (neither is all ones), res_o is never the all-ones word.
- R5: Parameter TOPO selects the prefix network: TOPO_KS (encoding 0) gives the Kogge-Stone tree and TOPO_BK (encoding 1) gives the Brent-Kung network. Both give identical results for every operand pair.
- R6: Parameter W sets the residue width, with a default of 8. The behaviour in R1 to R4 holds for other widths, including W = 5 (modulus 31).
- R7: Zero is the identity: with opb_i = 0 and opa_i in range, res_o equals opa_i. With both operands 0, res_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First residue operand, 0 to 2^W−2 |
| opb_i | input | W | Second residue operand, 0 to 2^W−2 |
| res_o | output | W | Sum modulo 2^W−1, never all ones |

## Verification
The increment is triggered by two separate causes. The first is a prefix carry-out, and it coincides with an all-propagate pattern only in the sense that the two are mutually exclusive. The second is the all-propagate case with no carry. The test must reach both causes, and it must also reach the boundary where a carry-out produces a raw sum that ripples the increment through several low bits.

Every operand pair at W = 8 is applied to both topologies, and every pair at W = 5 is applied as well. Each result is judged against (a+b) mod (2^W−1), computed with integers in the bench. Each pair is tagged by whether its true sum lies below the modulus, exactly on it, or above it. The two topologies are also compared with each other on every cycle.

// File: rtl/modm1_pkg.sv
package modm1_pkg;

  // Prefix network selection
  typedef enum logic [0:0] {
    TOPO_KS = 1'b0,
    TOPO_BK = 1'b1
  } topo_e;

endpackage

// File: rtl/modm1_pg.sv
// Bitwise propagate / generate formation.
module modm1_pg #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);

  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;

endmodule

// File: rtl/modm1_prefix.sv
// Carry prefix network: grp_g_o[i] is the carry out of bits 0..i.
module modm1_prefix
  import modm1_pkg::*;
#(
  parameter int    W    = 8,
  parameter topo_e TOPO = TOPO_KS
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  output logic [W-1:0] grp_g_o
);

  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  generate
    if (TOPO == TOPO_KS) begin : g_ks
      // LVL stages of span-doubling black cells
      logic [W-1:0] gs [0:LVL];
      logic [W-1:0] ps [0:LVL-1];
      assign gs[0] = g_i;
      assign ps[0] = p_i;
      for (genvar s = 0; s < LVL; s++) begin : g_stage
        localparam int D = 1 << s;
        for (genvar i = 0; i < W; i++) begin : g_bit
          if (i >= D) begin : g_cell
            assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
            if (s + 1 < LVL) begin : g_pp
              assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
            end
          end else begin : g_pass
            assign gs[s+1][i] = gs[s][i];
            if (s + 1 < LVL) begin : g_pp
              assign ps[s+1][i] = ps[s][i];
            end
          end
        end
      end
      assign grp_g_o = gs[LVL];
    end else begin : g_bk
      // Up-sweep over LVL stages, then down-sweep over LVL-1 stages
      localparam int NS = 2 * LVL - 1;
      logic [W-1:0] gs [0:NS];
      logic [W-1:0] ps [0:NS-1];
      assign gs[0] = g_i;
      assign ps[0] = p_i;
      for (genvar s = 0; s < NS; s++) begin : g_stage
        localparam bit UP = (s < LVL);
        localparam int LV = UP ? s : (2 * LVL - 2 - s);
        localparam int D  = 1 << LV;
        for (genvar i = 0; i < W; i++) begin : g_bit
          localparam bit ACT = UP ? (((i + 1) % (2 * D)) == 0)
                                  : ((((i + 1) % (2 * D)) == D) && (i >= 2 * D));
          if (ACT) begin : g_cell
            assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
            if (s + 1 < NS) begin : g_pp
              assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
            end
          end else begin : g_pass
            assign gs[s+1][i] = gs[s][i];
            if (s + 1 < NS) begin : g_pp
              assign ps[s+1][i] = ps[s][i];
            end
          end
        end
      end
      assign grp_g_o = gs[NS];
    end
  endgenerate

endmodule

// File: rtl/modm1_excess1.sv
// Conditional +1 built from an AND chain and XORs; final carry dropped.
module modm1_excess1 #(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] toggle;

  assign toggle[0] = inc_i;
  generate
    for (genvar i = 1; i < W; i++) begin : g_chain
      assign toggle[i] = toggle[i-1] & sum_i[i-1];
    end
  endgenerate

  assign sum_o = sum_i ^ toggle;

  // Correction stage either passes the raw sum or adds exactly one
  always_comb begin
    if (!$isunknown({inc_i, sum_i})) begin
      if (!inc_i) begin
        p_pass_when_idle_r1: assert (sum_o == sum_i)
          else $error("excess-one changed sum without increment");
      end else begin
        p_bump_by_one_r2: assert (sum_o == W'(sum_i + 1'b1))
          else $error("excess-one did not add one");
      end
    end
  end

endmodule

// File: rtl/modm1_adder.sv
module modm1_adder
  import modm1_pkg::*;
#(
  parameter int    W    = 8,
  parameter topo_e TOPO = TOPO_KS
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] res_o
);

  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] grp_g;
  logic [W-1:0] raw_sum;
  logic         carry_out;
  logic         all_prop;
  logic         bump;

  modm1_pg #(.W(W)) u_pg (
    .a_i (opa_i),
    .b_i (opb_i),
    .p_o (bit_p),
    .g_o (bit_g)
  );

  modm1_prefix #(.W(W), .TOPO(TOPO)) u_prefix (
    .p_i     (bit_p),
    .g_i     (bit_g),
    .grp_g_o (grp_g)
  );

  // Sum bits from propagate and incoming carry
  assign raw_sum[0] = bit_p[0];
  generate
    for (genvar i = 1; i < W; i++) begin : g_sum
      assign raw_sum[i] = bit_p[i] ^ grp_g[i-1];
    end
  endgenerate

  // Increment control taken from the prefix network
  assign carry_out = grp_g[W-1];
  assign all_prop  = &bit_p;
  assign bump      = carry_out | all_prop;

  modm1_excess1 #(.W(W)) u_inc (
    .sum_i (raw_sum),
    .inc_i (bump),
    .sum_o (res_o)
  );

  always_comb begin
    if (!$isunknown({opa_i, opb_i, res_o, raw_sum, carry_out})) begin
      if ((opa_i != '1) && (opb_i != '1)) begin
        p_no_all_ones_r4: assert (res_o != '1)
          else $error("all-ones result for in-range operands");
      end
      if ((opb_i == '0) && (opa_i != '1)) begin
        p_zero_identity_r7: assert (res_o == opa_i)
          else $error("adding zero changed the operand");
      end
      if (carry_out) begin
        p_wrap_below_operand_r2: assert (raw_sum < opa_i)
          else $error("carry-out without wrapped raw sum");
      end
      if (opa_i + opb_i == {W{1'b1}} && (opa_i & opb_i) == '0) begin
        p_modulus_to_zero_r3: assert (res_o == '0)
          else $error("sum equal to modulus not mapped to zero");
      end
    end
  end

endmodule

// File: tb/modm1_adder_bench.sv
module modm1_adder_bench;
  import modm1_pkg::*;

  logic clk;
  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] a8, b8;
  logic [7:0] res_ks, res_bk;
  logic [4:0] a5, b5;
  logic [4:0] res5_ks, res5_bk;

  modm1_adder #(.W(8), .TOPO(TOPO_KS)) u_modm1_adder (
    .opa_i(a8), .opb_i(b8), .res_o(res_ks));
  modm1_adder #(.W(8), .TOPO(TOPO_BK)) u_modm1_adder_bk (
    .opa_i(a8), .opb_i(b8), .res_o(res_bk));
  modm1_adder #(.W(5), .TOPO(TOPO_KS)) u_modm1_adder_w5k (
    .opa_i(a5), .opb_i(b5), .res_o(res5_ks));
  modm1_adder #(.W(5), .TOPO(TOPO_BK)) u_modm1_adder_w5b (
    .opa_i(a5), .opb_i(b5), .res_o(res5_bk));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply a pair on the falling edge, judge after the next rising edge
  task automatic apply8(input int a, input int b);
    @(negedge clk);
    a8 = 8'(a);
    b8 = 8'(b);
    @(posedge clk);
    #1;
  endtask

  task automatic apply5(input int a, input int b);
    @(negedge clk);
    a5 = 5'(a);
    b5 = 5'(b);
    @(posedge clk);
    #1;
  endtask

  initial begin
    a8 = '0; b8 = '0; a5 = '0; b5 = '0;

    // R7: both operands zero at start
    apply8(0, 0);
    chk("R7 zero+zero ks", int'(res_ks), 0);
    chk("R7 zero+zero bk", int'(res_bk), 0);

    // Exhaustive W=8 sweep on both topologies
    for (int a = 0; a < 255; a++) begin
      for (int b = 0; b < 255; b++) begin
        int sum;
        int exp;
        string tag;
        apply8(a, b);
        sum = a + b;
        exp = sum % 255;
        if (sum == 255)      tag = "R3";
        else if (sum >= 256) tag = "R2";
        else                 tag = "R1";
        chk($sformatf("%s ks a=%0d b=%0d", tag, a, b), int'(res_ks), exp);
        chk($sformatf("%s bk a=%0d b=%0d", tag, a, b), int'(res_bk), exp);
        // R5: topologies agree
        chk($sformatf("R5 ks/bk a=%0d b=%0d", a, b), int'(res_bk), int'(res_ks));
        // R4: all-ones never produced
        if (res_ks == 8'hFF) chk($sformatf("R4 a=%0d b=%0d", a, b), int'(res_ks), 0);
        if (b == 0) chk($sformatf("R7 identity a=%0d", a), int'(res_ks), a);
      end
    end

    // R6: narrower width, modulus 31
    for (int a = 0; a < 31; a++) begin
      for (int b = 0; b < 31; b++) begin
        apply5(a, b);
        chk($sformatf("R6 w5 ks a=%0d b=%0d", a, b), int'(res5_ks), (a + b) % 31);
        chk($sformatf("R6 w5 bk a=%0d b=%0d", a, b), int'(res5_bk), (a + b) % 31);
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule